// File: doc/BRIEF.md
# Configuration Bus Command Bridge

This block lets software issue one command at a time to board controllers over a narrow configuration bus. Software clears the status register, writes the outbound data word when it wants a write, and then writes a control word. Setting the control word's top bit starts a transaction. That top bit reads back as a busy flag until the transaction is over.

While the bridge is busy, it offers a request on a valid/ready handshake. The request carries the packed routing word and the write data. When the request has been accepted, the bridge waits for a response pulse that returns read data and an error flag. It then writes a completion code into the status register and drops busy. If no response arrives within the cycle limit taken from the `resp_timeout` input at the start, the bridge ends the transaction on its own. Completion is polled, so the block has no interrupt.

Top module: `cfgbus_bridge`

## Requirements
- R1: After reset, all three registers read as zero. The register offsets are data 0xA0, control 0xA4 and status 0xA8. Status is held in bits 1:0 and the remaining status bits read zero. Any other offset reads zero.
- R2: Writing control with bit 31 set while idle starts a transaction. From the next cycle, control bit 31 reads 1 and `req_valid` is high. Writing control with bit 31 clear while idle only stores the fields, and no request is issued.
- R3: `req_cmd` is packed as follows. Bit 31 is 1. Bit 30 selects a write (1) or a read (0). Bits 29:26 hold the controller class, 25:20 the function, 17:16 the site, 15:12 the position and 11:0 the device. Bits 19:18 are forced to zero here and also in the control readback. `req_wdata` equals the data register.
- R4: `req_valid` stays high with a stable `req_cmd` until `req_ready` is seen. A `resp_valid` that arrives before the request is accepted is ignored.
- R5: A response without error ends a read with status 01 and loads `resp_rdata` into the data register. Busy clears on the same edge.
- R6: A response without error ends a write with status 01 and leaves the data register unchanged.
- R7: A response with `resp_err` set gives status 10 and leaves the data register unchanged.
- R8: Let T be the `resp_timeout` value sampled at the start. If no response has arrived by the (T+1)-th clock edge after the start write, the bridge sets status 11 and clears busy on that edge. A response that arrives on that same edge takes priority.
- R9: While busy, writes to the control, data and status registers are ignored.
- R10: While idle, a write to status stores bits 1:0 of the write data. This lets software clear status by writing zero.
- R11: A `resp_valid` pulse while idle changes neither the status nor the data register.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| bus_addr | input | 8 | Register byte address |
| bus_we | input | 1 | Register write strobe |
| bus_wdata | input | 32 | Register write data |
| bus_rdata | output | 32 | Register read data (combinational) |
| resp_timeout | input | 16 | Response cycle limit, sampled at start |
| req_valid | output | 1 | Request offered to the controller side |
| req_ready | input | 1 | Controller accepts the request |
| req_cmd | output | 32 | Packed command word |
| req_wdata | output | 32 | Outbound write data |
| resp_valid | input | 1 | Controller response strobe |
| resp_rdata | input | 32 | Returned read data |
| resp_err | input | 1 | Controller reports a failure |

## Verification
A corrupted state register shows up in two places at the ports. Control bit 31 would read back wrongly, and `req_valid` would stay high or drop on an edge where it should not. Both are visible one cycle after the start write or after the handshake. A wrong timeout counter moves the edge at which status becomes 11, so the bench counts edges exactly around the limit. It also places a response on the last legal edge. A fault in the routing latch or the data latch appears in `req_cmd`, `req_wdata` or the data register readback straight after a transaction ends, or straight after a write that was issued while busy.

// File: rtl/cfgbus_bridge.sv
module cfgbus_bridge #(
  parameter int AW = 8,
  parameter int TW = 16,
  parameter logic [AW-1:0] DATA_OFS = 'hA0,
  parameter logic [AW-1:0] CTRL_OFS = 'hA4,
  parameter logic [AW-1:0] STAT_OFS = 'hA8
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic [AW-1:0] bus_addr,
  input  logic          bus_we,
  input  logic [31:0]   bus_wdata,
  output logic [31:0]   bus_rdata,
  input  logic [TW-1:0] resp_timeout,
  output logic          req_valid,
  input  logic          req_ready,
  output logic [31:0]   req_cmd,
  output logic [31:0]   req_wdata,
  input  logic          resp_valid,
  input  logic [31:0]   resp_rdata,
  input  logic          resp_err
);
  typedef enum logic [1:0] {S_IDLE, S_REQ, S_WAIT} state_t;

  state_t        state_q;
  logic [30:0]   ctrl_q;
  logic [31:0]   data_q;
  logic [1:0]    stat_q;
  logic [TW-1:0] cnt_q, lim_q;

  wire busy     = (state_q != S_IDLE);
  wire got_resp = (state_q == S_WAIT) && resp_valid;
  wire expired  = busy && !got_resp && (cnt_q == lim_q);
  wire is_write = ctrl_q[30];

  assign req_valid = (state_q == S_REQ);
  assign req_cmd   = {1'b1, ctrl_q};
  assign req_wdata = data_q;

  always_comb begin
    bus_rdata = '0;
    if (bus_addr == DATA_OFS) bus_rdata = data_q;
    else if (bus_addr == CTRL_OFS) bus_rdata = {busy, ctrl_q};
    else if (bus_addr == STAT_OFS) bus_rdata = {30'd0, stat_q};
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      state_q <= S_IDLE;
      ctrl_q  <= '0;
      data_q  <= '0;
      stat_q  <= '0;
      cnt_q   <= '0;
      lim_q   <= '0;
    end else if (!busy) begin
      if (bus_we) begin
        if (bus_addr == DATA_OFS) data_q <= bus_wdata;
        if (bus_addr == STAT_OFS) stat_q <= bus_wdata[1:0];
        if (bus_addr == CTRL_OFS) begin
          ctrl_q <= {bus_wdata[30:20], 2'b00, bus_wdata[17:0]};
          if (bus_wdata[31]) begin
            state_q <= S_REQ;
            cnt_q   <= '0;
            lim_q   <= resp_timeout;
          end
        end
      end
    end else if (got_resp) begin
      stat_q  <= resp_err ? 2'b10 : 2'b01;
      if (!resp_err && !is_write) data_q <= resp_rdata;
      state_q <= S_IDLE;
    end else if (expired) begin
      stat_q  <= 2'b11;
      state_q <= S_IDLE;
    end else begin
      cnt_q <= cnt_q + 1'b1;
      if (state_q == S_REQ && req_ready) state_q <= S_WAIT;
    end
  end

  assert_start_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (!busy && bus_we && bus_addr == CTRL_OFS && bus_wdata[31]) |=> (req_valid && req_cmd[31]));

  assert_req_hold_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (req_valid && !req_ready && !expired) |=> (req_valid && $stable(req_cmd) && $stable(req_wdata)));

  assert_finish_status_R5: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(busy) |-> (stat_q != 2'b00));

  assert_timeout_R8: assert property (@(posedge clk) disable iff (!rst_n)
    expired |=> (!busy && stat_q == 2'b11));

  assert_busy_ignore_R9: assert property (@(posedge clk) disable iff (!rst_n)
    (busy && bus_we) |=> $stable(ctrl_q));
endmodule

// File: tb/cfgbus_bridge_tb_top.sv
module cfgbus_bridge_tb_top;
  localparam logic [7:0] A_DATA = 8'hA0, A_CTRL = 8'hA4, A_STAT = 8'hA8;

  logic clk = 0, rst_n = 0;
  logic [7:0]  bus_addr = 0;
  logic        bus_we = 0;
  logic [31:0] bus_wdata = 0, bus_rdata;
  logic [15:0] resp_timeout = 16'd1000;
  logic        req_valid, req_ready = 0;
  logic [31:0] req_cmd, req_wdata;
  logic        resp_valid = 0, resp_err = 0;
  logic [31:0] resp_rdata = 0;

  int checks = 0, errors = 0;
  bit done = 0;

  always #2 clk = ~clk;

  cfgbus_bridge dut_i (
    .clk(clk), .rst_n(rst_n), .bus_addr(bus_addr), .bus_we(bus_we),
    .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .resp_timeout(resp_timeout),
    .req_valid(req_valid), .req_ready(req_ready), .req_cmd(req_cmd),
    .req_wdata(req_wdata), .resp_valid(resp_valid), .resp_rdata(resp_rdata),
    .resp_err(resp_err)
  );

  function automatic logic [31:0] exp_cmd(input logic [31:0] raw);
    return {1'b1, raw[30:20], 2'b00, raw[17:0]};
  endfunction

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic wr(input logic [7:0] a, input logic [31:0] d);
    @(negedge clk); bus_addr = a; bus_we = 1; bus_wdata = d;
    @(negedge clk); bus_we = 0;
  endtask

  task automatic rd(input logic [7:0] a, output logic [31:0] d);
    bus_addr = a; #1; d = bus_rdata;
  endtask

  task automatic txn(input logic wrb, input logic [31:0] raw, input logic [31:0] wdat,
                     input logic [31:0] rdat, input logic err, input int rdly,
                     input int pdly, input logic poke);
    logic [31:0] v, ctl, expd;
    ctl = {1'b1, wrb, raw[29:0]};
    wr(A_STAT, 0);
    wr(A_DATA, wdat);
    wr(A_CTRL, ctl);
    rd(A_CTRL, v);
    check("R2 busy after start", {31'd0, v[31]}, 1);
    check("R3 cmd packing", req_cmd, exp_cmd(ctl));
    check("R3 wdata", req_wdata, wdat);
    if (poke) begin
      wr(A_CTRL, ~ctl);
      wr(A_DATA, ~wdat);
      wr(A_STAT, 3);
      rd(A_DATA, v);
      check("R9 data write ignored", v, wdat);
      rd(A_STAT, v);
      check("R9 status write ignored", v, 0);
      check("R9 ctrl write ignored", req_cmd, exp_cmd(ctl));
      resp_valid = 1; resp_rdata = ~rdat;
      @(negedge clk); resp_valid = 0;
      check("R4 early response ignored", {31'd0, req_valid}, 1);
    end
    repeat (rdly) @(negedge clk);
    check("R4 valid held", {31'd0, req_valid}, 1);
    req_ready = 1;
    @(negedge clk); req_ready = 0;
    check("R4 accepted", {31'd0, req_valid}, 0);
    repeat (pdly) @(negedge clk);
    resp_valid = 1; resp_rdata = rdat; resp_err = err;
    @(negedge clk); resp_valid = 0; resp_err = 0;
    rd(A_CTRL, v);
    check("R5 busy cleared", {31'd0, v[31]}, 0);
    rd(A_STAT, v);
    check(err ? "R7 status" : (wrb ? "R6 status" : "R5 status"), v, err ? 2 : 1);
    expd = (!wrb && !err) ? rdat : wdat;
    rd(A_DATA, v);
    check(err ? "R7 data" : (wrb ? "R6 data" : "R5 data"), v, expd);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      errors++;
      $display("FAIL watchdog actual=hung expected=finished");
      $display("  Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end

  initial begin
    logic [31:0] v, raw;
    void'($urandom(32'h5eed_c0de));
    repeat (3) @(negedge clk);
    rst_n = 1;
    @(negedge clk);
    rd(A_DATA, v); check("R1 data reset", v, 0);
    rd(A_CTRL, v); check("R1 ctrl reset", v, 0);
    rd(A_STAT, v); check("R1 status reset", v, 0);
    rd(8'h10, v);  check("R1 unmapped", v, 0);
    check("R1 no request", {31'd0, req_valid}, 0);

    wr(A_STAT, 32'hFFFF_FFFF);
    rd(A_STAT, v); check("R10 status set", v, 3);
    wr(A_STAT, 0);
    rd(A_STAT, v); check("R10 status clear", v, 0);

    wr(A_CTRL, 32'h7FFF_FFFF);
    @(negedge clk);
    check("R2 no start", {31'd0, req_valid}, 0);
    rd(A_CTRL, v); check("R3 reserved masked", v, 32'h7FF3_FFFF);

    wr(A_DATA, 32'hCAFE_0001);
    resp_valid = 1; resp_rdata = 32'h1234_5678;
    @(negedge clk); resp_valid = 0;
    rd(A_DATA, v); check("R11 data unchanged", v, 32'hCAFE_0001);
    rd(A_STAT, v); check("R11 status unchanged", v, 0);

    txn(0, 32'h1555_5555, 32'h1111_2222, 32'hDEAD_BEEF, 0, 0, 0, 1);
    txn(1, 32'h2AAA_AAAA, 32'h3333_4444, 32'h0BAD_F00D, 0, 2, 3, 0);
    txn(0, 32'h0C0F_3ABC, 32'h5555_6666, 32'h7777_8888, 1, 1, 1, 0);

    for (int i = 0; i < 40; i++) begin
      raw = $urandom;
      txn(raw[30], raw, $urandom, $urandom, ($urandom % 4) == 0,
          $urandom % 6, $urandom % 6, ($urandom % 3) == 0);
    end

    resp_timeout = 5;
    wr(A_STAT, 0);
    wr(A_CTRL, 32'h8000_0001);
    resp_timeout = 1000;
    repeat (5) @(negedge clk);
    rd(A_CTRL, v); check("R8 busy before limit", {31'd0, v[31]}, 1);
    @(negedge clk);
    rd(A_CTRL, v); check("R8 busy dropped at limit", {31'd0, v[31]}, 0);
    rd(A_STAT, v); check("R8 timeout status", v, 3);

    resp_timeout = 5;
    wr(A_STAT, 0);
    wr(A_DATA, 0);
    wr(A_CTRL, 32'h8000_0002);
    req_ready = 1;
    @(negedge clk); req_ready = 0;
    repeat (4) @(negedge clk);
    resp_valid = 1; resp_rdata = 32'hFACE_B00C;
    @(negedge clk); resp_valid = 0;
    rd(A_STAT, v); check("R8 response wins at limit", v, 1);
    rd(A_DATA, v); check("R8 R5 data at limit", v, 32'hFACE_B00C);

    done = 1;
    $display("  Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule